// File: doc/BRIEF.md
# Alert-on-Update Cache Tag Unit

This unit keeps one watch bit per line of a small first-level data cache. Software sets the bit with an alert-load. If a watched line is lost, the unit raises an alert and sends the thread to a software handler. A line is lost when a remote core takes exclusive ownership of it, when a remote core invalidates it, or when the replacement logic evicts it. The unit stores only the watch bit and the address tag of each line. Data and the full coherence protocol stay outside it.

Delivering an alert blocks all further alerts until the handler reports that it has finished. While alerts are blocked, the first new alert condition goes into a single pending slot and any later ones are dropped. The pending alert comes out as soon as the handler exits. Software can also clear every watch bit in one cycle.

Top module: `aou_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `alert_o` and `redirect_o` are 0. `alert_cause_o` and `alert_addr_o` are 0 in every cycle in which `alert_o` is 0.
- R2: An alert-load (`req_op_i` = 2'b01) sets the watch bit of the line at `req_addr_i`. A plain load (2'b10) leaves the watch state unchanged.
- R3: A snoop of kind get-exclusive (2'b01) or invalidate (2'b10) that matches a watched line raises `alert_o` for one cycle, in the cycle after the snoop. In that cycle `alert_cause_o` = 2'b01 and `alert_addr_o` holds the line address.
- R4: A shared-read snoop (kind 2'b00) never raises an alert, and the line stays watched.
- R5: An eviction that matches a watched line raises `alert_o` in the next cycle, with `alert_cause_o` = 2'b10 and the line address.
- R6: A snoop or eviction whose address does not match a watched line raises no alert. This includes an address with the same index but a different tag.
- R7: A line that raises an alert is no longer watched, so a second snoop or eviction of that line raises no alert.
- R8: `redirect_o` rises together with `alert_o` and stays high until a handler exit (`req_op_i` = 2'b11). It then falls in the next cycle unless an alert is delivered in that cycle. A handler exit while `redirect_o` is low has no effect.
- R9: While `redirect_o` is high, no alert is output. The first new condition is held as pending, and later conditions are dropped. The pending alert, with its original cause and address, appears in the cycle after the handler exit. If no alert is pending, a condition that arrives in the same cycle as the exit is delivered in the next cycle.
- R10: `clear_all_i` clears every watch bit, so no line that was watched before it can raise an alert afterwards.
- R11: When a watched snoop hit and a watched eviction hit occur in the same cycle, one alert is delivered with cause 2'b01 and the snooped address. Both lines stop being watched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_op_i | input | 2 | 01 alert-load, 10 plain load, 11 handler exit |
| req_addr_i | input | LINE_AW | Line address of the request |
| clear_all_i | input | 1 | Clear every watch bit |
| snp_valid_i | input | 1 | Snoop valid |
| snp_kind_i | input | 2 | 00 shared read, 01 get-exclusive, 10 invalidate |
| snp_addr_i | input | LINE_AW | Snooped line address |
| evict_valid_i | input | 1 | Eviction notice valid |
| evict_addr_i | input | LINE_AW | Evicted line address |
| alert_o | output | 1 | One-cycle alert strobe |
| alert_cause_o | output | 2 | 01 coherence, 10 capacity |
| alert_addr_o | output | LINE_AW | Address of the lost line |
| redirect_o | output | 1 | Thread is held in the handler; alerts are blocked |

## Verification
The bench tries several patterns and each one rules out a different fault:
- Watched lines are lost one at a time, by a get-exclusive snoop, by an invalidate snoop and by an eviction. This separates the two cause codes and shows that the address is carried through correctly.
- Plain loads, shared-read snoops and same-index addresses with a different tag are sent in. These show that only a real tag match on a watched line can raise an alert.
- Several losses are sent in while the handler runs. This shows that only the first is kept and that it is released exactly one cycle after the exit.
- Snoop and eviction hits arrive in the same cycle, and a new condition arrives together with a handler exit. These cover the priority and the unmasking paths.

// File: rtl/aou_pkg.sv
package aou_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_ALOAD = 2'b01,
      OP_LOAD  = 2'b10,
      OP_HEXIT = 2'b11
   } req_op_e;

   typedef enum logic [1:0] {
      SNP_RDSHARED = 2'b00,
      SNP_GETX     = 2'b01,
      SNP_INVAL    = 2'b10,
      SNP_RSVD     = 2'b11
   } snp_kind_e;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_COH  = 2'b01,
      CAUSE_CAP  = 2'b10
   } cause_e;

endpackage

// File: rtl/aou_watch_array.sv
module aou_watch_array #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned LINE_AW   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_v_i,
   input  logic [LINE_AW-1:0] set_addr_i,
   input  logic               clr_all_i,
   input  logic               snp_v_i,
   input  logic [LINE_AW-1:0] snp_addr_i,
   input  logic               ev_v_i,
   input  logic [LINE_AW-1:0] ev_addr_i,
   output logic               snp_hit_o,
   output logic               ev_hit_o
);
   localparam int unsigned IDX_W = $clog2(NUM_LINES);
   localparam int unsigned TAG_W = LINE_AW - IDX_W;

   logic [NUM_LINES-1:0] watch_vec;
   logic [TAG_W-1:0]     tag_arr [NUM_LINES];

   logic [IDX_W-1:0] set_idx, snp_idx, ev_idx;
   logic [TAG_W-1:0] set_tag, snp_tag, ev_tag;

   assign set_idx = set_addr_i[IDX_W-1:0];
   assign snp_idx = snp_addr_i[IDX_W-1:0];
   assign ev_idx  = ev_addr_i[IDX_W-1:0];
   assign set_tag = set_addr_i[LINE_AW-1:IDX_W];
   assign snp_tag = snp_addr_i[LINE_AW-1:IDX_W];
   assign ev_tag  = ev_addr_i[LINE_AW-1:IDX_W];

   assign snp_hit_o = snp_v_i && watch_vec[snp_idx] && (tag_arr[snp_idx] == snp_tag);
   assign ev_hit_o  = ev_v_i  && watch_vec[ev_idx]  && (tag_arr[ev_idx]  == ev_tag);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic             w_q;
      logic [TAG_W-1:0] t_q;
      logic             lost;
      logic             arm;

      assign lost = (snp_hit_o && (snp_idx == IDX_W'(g))) ||
                    (ev_hit_o  && (ev_idx  == IDX_W'(g)));
      assign arm  = set_v_i && (set_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= 1'b0;
            t_q <= '0;
         end else begin
            if (clr_all_i || lost) begin
               w_q <= 1'b0;
            end
            if (arm) begin
               w_q <= 1'b1;
               t_q <= set_tag;
            end
         end
      end

      assign watch_vec[g] = w_q;
      assign tag_arr[g]   = t_q;
   end

endmodule

// File: rtl/aou_cause_sel.sv
module aou_cause_sel import aou_pkg::*; #(
   parameter int unsigned LINE_AW = 16
) (
   input  logic               snp_hit_i,
   input  logic [LINE_AW-1:0] snp_addr_i,
   input  logic               ev_hit_i,
   input  logic [LINE_AW-1:0] ev_addr_i,
   output logic               cond_v_o,
   output cause_e             cond_cause_o,
   output logic [LINE_AW-1:0] cond_addr_o
);
   always_comb begin
      cond_v_o     = 1'b0;
      cond_cause_o = CAUSE_NONE;
      cond_addr_o  = '0;
      if (snp_hit_i) begin
         cond_v_o     = 1'b1;
         cond_cause_o = CAUSE_COH;
         cond_addr_o  = snp_addr_i;
      end else if (ev_hit_i) begin
         cond_v_o     = 1'b1;
         cond_cause_o = CAUSE_CAP;
         cond_addr_o  = ev_addr_i;
      end
   end
endmodule

// File: rtl/aou_alert_ctrl.sv
module aou_alert_ctrl import aou_pkg::*; #(
   parameter int unsigned LINE_AW = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cond_v_i,
   input  cause_e             cond_cause_i,
   input  logic [LINE_AW-1:0] cond_addr_i,
   input  logic               exit_i,
   output logic               alert_o,
   output logic [1:0]         cause_o,
   output logic [LINE_AW-1:0] addr_o,
   output logic               redirect_o
);
   logic               mask_q, pend_v_q, alert_q;
   cause_e             pend_cause_q, cause_q;
   logic [LINE_AW-1:0] pend_addr_q, addr_q;

   logic               nxt_mask, nxt_pv, nxt_alert;
   cause_e             nxt_pc, nxt_cause;
   logic [LINE_AW-1:0] nxt_pa, nxt_addr;

   always_comb begin
      nxt_alert = 1'b0;
      nxt_cause = CAUSE_NONE;
      nxt_addr  = '0;
      nxt_mask  = mask_q;
      nxt_pv    = pend_v_q;
      nxt_pc    = pend_cause_q;
      nxt_pa    = pend_addr_q;
      if (mask_q && !exit_i) begin
         if (cond_v_i && !pend_v_q) begin
            nxt_pv = 1'b1;
            nxt_pc = cond_cause_i;
            nxt_pa = cond_addr_i;
         end
      end else if (pend_v_q) begin
         nxt_alert = 1'b1;
         nxt_cause = pend_cause_q;
         nxt_addr  = pend_addr_q;
         nxt_mask  = 1'b1;
         nxt_pv    = cond_v_i;
         nxt_pc    = cond_v_i ? cond_cause_i : CAUSE_NONE;
         nxt_pa    = cond_v_i ? cond_addr_i : '0;
      end else if (cond_v_i) begin
         nxt_alert = 1'b1;
         nxt_cause = cond_cause_i;
         nxt_addr  = cond_addr_i;
         nxt_mask  = 1'b1;
      end else begin
         nxt_mask  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q       <= 1'b0;
         pend_v_q     <= 1'b0;
         pend_cause_q <= CAUSE_NONE;
         pend_addr_q  <= '0;
         alert_q      <= 1'b0;
         cause_q      <= CAUSE_NONE;
         addr_q       <= '0;
      end else begin
         mask_q       <= nxt_mask;
         pend_v_q     <= nxt_pv;
         pend_cause_q <= nxt_pc;
         pend_addr_q  <= nxt_pa;
         alert_q      <= nxt_alert;
         cause_q      <= nxt_cause;
         addr_q       <= nxt_addr;
      end
   end

   assign alert_o    = alert_q;
   assign cause_o    = cause_q;
   assign addr_o     = addr_q;
   assign redirect_o = mask_q;
endmodule

// File: rtl/aou_unit.sv
module aou_unit import aou_pkg::*; #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned LINE_AW   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [1:0]         req_op_i,
   input  logic [LINE_AW-1:0] req_addr_i,
   input  logic               clear_all_i,
   input  logic               snp_valid_i,
   input  logic [1:0]         snp_kind_i,
   input  logic [LINE_AW-1:0] snp_addr_i,
   input  logic               evict_valid_i,
   input  logic [LINE_AW-1:0] evict_addr_i,
   output logic               alert_o,
   output logic [1:0]         alert_cause_o,
   output logic [LINE_AW-1:0] alert_addr_o,
   output logic               redirect_o
);
   localparam int unsigned IDX_W = $clog2(NUM_LINES);

   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("aou_unit: NUM_LINES must be a power of two of at least 2");
   end
   if (LINE_AW <= IDX_W) begin : g_bad_aw
      $error("aou_unit: LINE_AW must exceed the index width");
   end

   logic               set_v, snp_chk_v, exit_v;
   logic               snp_hit, ev_hit;
   logic               cond_v;
   cause_e             cond_cause;
   logic [LINE_AW-1:0] cond_addr;

   assign set_v     = req_valid_i && (req_op_i == OP_ALOAD);
   assign exit_v    = req_valid_i && (req_op_i == OP_HEXIT);
   assign snp_chk_v = snp_valid_i && ((snp_kind_i == SNP_GETX) || (snp_kind_i == SNP_INVAL));

   aou_watch_array #(.NUM_LINES(NUM_LINES), .LINE_AW(LINE_AW)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_v_i    (set_v),
      .set_addr_i (req_addr_i),
      .clr_all_i  (clear_all_i),
      .snp_v_i    (snp_chk_v),
      .snp_addr_i (snp_addr_i),
      .ev_v_i     (evict_valid_i),
      .ev_addr_i  (evict_addr_i),
      .snp_hit_o  (snp_hit),
      .ev_hit_o   (ev_hit)
   );

   aou_cause_sel #(.LINE_AW(LINE_AW)) u_sel (
      .snp_hit_i    (snp_hit),
      .snp_addr_i   (snp_addr_i),
      .ev_hit_i     (ev_hit),
      .ev_addr_i    (evict_addr_i),
      .cond_v_o     (cond_v),
      .cond_cause_o (cond_cause),
      .cond_addr_o  (cond_addr)
   );

   aou_alert_ctrl #(.LINE_AW(LINE_AW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cond_v_i     (cond_v),
      .cond_cause_i (cond_cause),
      .cond_addr_i  (cond_addr),
      .exit_i       (exit_v),
      .alert_o      (alert_o),
      .cause_o      (alert_cause_o),
      .addr_o       (alert_addr_o),
      .redirect_o   (redirect_o)
   );
endmodule

// File: rtl/aou_unit_chk.sv
module aou_unit_chk #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned LINE_AW   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid_i,
   input logic [1:0]         req_op_i,
   input logic               snp_valid_i,
   input logic [1:0]         snp_kind_i,
   input logic               evict_valid_i,
   input logic               alert_o,
   input logic [1:0]         alert_cause_o,
   input logic [LINE_AW-1:0] alert_addr_o,
   input logic               redirect_o
);
   logic exit_req;
   assign exit_req = req_valid_i && (req_op_i == 2'b11);

   // R3
   cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |-> (alert_cause_o == 2'b01 || alert_cause_o == 2'b10));

   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_o |-> (alert_cause_o == 2'b00 && alert_addr_o == '0));

   // R8
   alert_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |-> redirect_o);

   // R8
   redirect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !exit_req) |=> redirect_o);

   // R8
   rise_with_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(redirect_o) |-> alert_o);

   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !exit_req) |=> !alert_o);

   // R4
   shared_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid_i && snp_kind_i == 2'b00 && !evict_valid_i && !redirect_o) |=> !alert_o);
endmodule

bind aou_unit aou_unit_chk #(.NUM_LINES(NUM_LINES), .LINE_AW(LINE_AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid_i   (req_valid_i),
   .req_op_i      (req_op_i),
   .snp_valid_i   (snp_valid_i),
   .snp_kind_i    (snp_kind_i),
   .evict_valid_i (evict_valid_i),
   .alert_o       (alert_o),
   .alert_cause_o (alert_cause_o),
   .alert_addr_o  (alert_addr_o),
   .redirect_o    (redirect_o)
);

// File: tb/aou_unit_test.sv
module aou_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid_i = 1'b0;
   logic [1:0]    req_op_i = 2'b00;
   logic [AW-1:0] req_addr_i = '0;
   logic          clear_all_i = 1'b0;
   logic          snp_valid_i = 1'b0;
   logic [1:0]    snp_kind_i = 2'b00;
   logic [AW-1:0] snp_addr_i = '0;
   logic          evict_valid_i = 1'b0;
   logic [AW-1:0] evict_addr_i = '0;
   logic          alert_o;
   logic [1:0]    alert_cause_o;
   logic [AW-1:0] alert_addr_o;
   logic          redirect_o;

   aou_unit #(.NUM_LINES(NL), .LINE_AW(AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
      .clear_all_i(clear_all_i),
      .snp_valid_i(snp_valid_i), .snp_kind_i(snp_kind_i), .snp_addr_i(snp_addr_i),
      .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i),
      .alert_o(alert_o), .alert_cause_o(alert_cause_o),
      .alert_addr_o(alert_addr_o), .redirect_o(redirect_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // reference model state
   int wq[$];
   bit m_alert = 0, m_mask = 0, m_pend = 0;
   int m_cause = 0, m_addr = 0, m_pcause = 0, m_paddr = 0;

   always @(posedge clk) begin
      int cc, ca;
      bit coh, ex, sent;
      cyc++;
      if (!rst_n) begin
         wq.delete();
         m_alert = 0; m_mask = 0; m_pend = 0;
         m_cause = 0; m_addr = 0; m_pcause = 0; m_paddr = 0;
      end else begin
         cc = 0; ca = 0; coh = 0;
         if (snp_valid_i && (snp_kind_i == 2'b01 || snp_kind_i == 2'b10)) begin
            for (int i = wq.size() - 1; i >= 0; i--) begin
               if (wq[i] == int'(snp_addr_i)) begin
                  coh = 1; cc = 1; ca = int'(snp_addr_i);
                  wq.delete(i);
               end
            end
         end
         if (evict_valid_i) begin
            for (int i = wq.size() - 1; i >= 0; i--) begin
               if (wq[i] == int'(evict_addr_i)) begin
                  wq.delete(i);
                  if (!coh) begin cc = 2; ca = int'(evict_addr_i); end
               end
            end
         end
         if (clear_all_i) wq.delete();
         if (req_valid_i && req_op_i == 2'b01) begin
            for (int i = wq.size() - 1; i >= 0; i--) begin
               if ((wq[i] % NL) == (int'(req_addr_i) % NL)) wq.delete(i);
            end
            wq.push_back(int'(req_addr_i));
         end
         ex = req_valid_i && req_op_i == 2'b11 && m_mask;
         m_alert = 0; m_cause = 0; m_addr = 0;
         if (m_mask && !ex) begin
            if (cc != 0 && !m_pend) begin
               m_pend = 1; m_pcause = cc; m_paddr = ca;
            end
         end else begin
            sent = 0;
            if (m_pend) begin
               m_alert = 1; m_cause = m_pcause; m_addr = m_paddr; sent = 1;
               m_pend = (cc != 0); m_pcause = cc; m_paddr = ca;
            end else if (cc != 0) begin
               m_alert = 1; m_cause = cc; m_addr = ca; sent = 1;
            end
            m_mask = sent;
         end
      end
   end

   always @(negedge clk) begin
      if (cyc >= 1 && !done) begin
         checks++;
         if (alert_o !== m_alert || int'(alert_cause_o) != m_cause ||
             int'(alert_addr_o) != m_addr || redirect_o !== m_mask) begin
            failures++;
            $display("FAIL %s cyc=%0d act alert=%b cause=%0d addr=%h redir=%b exp alert=%b cause=%0d addr=%h redir=%b",
                     cur_req, cyc, alert_o, alert_cause_o, alert_addr_o, redirect_o,
                     m_alert, m_cause, m_addr[AW-1:0], m_mask);
         end
      end
   end

   task automatic put(input bit rv, input logic [1:0] rop, input int ra, input bit clr,
                      input bit sv, input logic [1:0] sk, input int sa,
                      input bit ev, input int ea);
      @(posedge clk); #1;
      req_valid_i = rv; req_op_i = rop; req_addr_i = AW'(ra);
      clear_all_i = clr;
      snp_valid_i = sv; snp_kind_i = sk; snp_addr_i = AW'(sa);
      evict_valid_i = ev; evict_addr_i = AW'(ea);
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) put(0, 2'b00, 0, 0, 0, 2'b00, 0, 0, 0);
   endtask

   task automatic aload(input int a);  put(1, 2'b01, a, 0, 0, 2'b00, 0, 0, 0); quiet(2); endtask
   task automatic pload(input int a);  put(1, 2'b10, a, 0, 0, 2'b00, 0, 0, 0); quiet(2); endtask
   task automatic hexit();             put(1, 2'b11, 0, 0, 0, 2'b00, 0, 0, 0); quiet(2); endtask
   task automatic snoop(input logic [1:0] k, input int a); put(0, 2'b00, 0, 0, 1, k, a, 0, 0); quiet(2); endtask
   task automatic evict(input int a);  put(0, 2'b00, 0, 0, 0, 2'b00, 0, 1, a); quiet(2); endtask
   task automatic clrall();            put(0, 2'b00, 0, 1, 0, 2'b00, 0, 0, 0); quiet(2); endtask

   initial begin
      // R1: reset values
      cur_req = "R1";
      quiet(3);
      rst_n = 1'b1;
      quiet(3);

      // R2 / R3: alert-load then get-exclusive and invalidate hits
      cur_req = "R3";
      aload(16'h0012);
      snoop(2'b01, 16'h0012);
      hexit();
      aload(16'h0022);
      snoop(2'b10, 16'h0022);
      hexit();
      cur_req = "R2";
      pload(16'h0034);
      snoop(2'b10, 16'h0034);

      // R4: shared read keeps the watch
      cur_req = "R4";
      aload(16'h0055);
      snoop(2'b00, 16'h0055);
      snoop(2'b10, 16'h0055);
      hexit();

      // R5: eviction gives capacity cause
      cur_req = "R5";
      aload(16'h0066);
      evict(16'h0066);
      hexit();

      // R6: same index, different tag
      cur_req = "R6";
      aload(16'h0107);
      snoop(2'b01, 16'h0207);
      evict(16'h0307);
      snoop(2'b10, 16'h0108);

      // R7: a lost line is no longer watched
      cur_req = "R7";
      snoop(2'b10, 16'h0012);
      evict(16'h0066);

      // R8: exit while idle is ignored, redirect held until exit
      cur_req = "R8";
      hexit();
      evict(16'h0107);
      quiet(4);
      hexit();

      // R9: pending slot keeps the first, drops the rest
      cur_req = "R9";
      aload(16'h0A18); aload(16'h0A19); aload(16'h0A1A);
      evict(16'h0A18);
      snoop(2'b10, 16'h0A19);
      evict(16'h0A1A);
      quiet(2);
      hexit();
      hexit();
      evict(16'h0A1A);
      // R9: condition in the same cycle as the exit, nothing pending
      aload(16'h0D1E); aload(16'h0D1F);
      evict(16'h0D1F);
      put(1, 2'b11, 0, 0, 0, 2'b00, 0, 1, 16'h0D1E); quiet(2);
      hexit();

      // R10: clear-all
      cur_req = "R10";
      aload(16'h0B1B); aload(16'h0B1C);
      clrall();
      snoop(2'b10, 16'h0B1B);
      evict(16'h0B1C);

      // R11: simultaneous snoop and eviction hits
      cur_req = "R11";
      aload(16'h0C11); aload(16'h0C13);
      put(0, 2'b00, 0, 0, 1, 2'b10, 16'h0C11, 1, 16'h0C13); quiet(2);
      hexit();
      evict(16'h0C13);
      snoop(2'b01, 16'h0C11);
      quiet(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule